// File: doc/BRIEF.md
# Dual-Clock Flagless FIFO Buffer

This block is a first-in first-out buffer whose write side and read side run on two independent clocks. Words enter on the write clock while the write enable is high. They leave in the same order on the read clock while the read enable is high. The write pointer and the read pointer are each built from a one-hot token ring and a small segment counter, and that pair is converted to a binary address into an inferred dual-port storage array. The read word is registered.

The block has no full, empty or level indication and no guard against overflow or underflow, so the logic around it must track occupancy. An asynchronous clear returns both pointers to location zero, which is the empty condition, and leaves the stored words in place. The polarity of the clear and the active edge of each clock are set by parameters. The clear is applied at once and released in step with each clock. A clear must be applied after power-up before the block is used. DEPTH must be a whole multiple of the ring length RING.

Top module: `flagless_dc_fifo`

## Requirements
- R1: Words are returned in the order they were written, and exactly DEPTH words can be written and then all read back intact.
- R2: Writes and reads are driven by unrelated clocks and may take place in the same period without disturbing each other.
- R3: `rd_data` is registered. It changes only at an active read edge where `rd_en` was high, and it holds its value while `rd_en` is low.
- R4: Each enabled active edge advances its pointer by exactly one location, and the pointer wraps from DEPTH-1 back to 0. The token ring always holds exactly one token.
- R5: Nothing blocks writes. With DEPTH+1 writes and no reads, the last word overwrites location 0, and the next read returns that last word.
- R6: The clear acts asynchronously and sets both pointers to location 0. The storage keeps its contents, so a read after a clear, with no new write, returns the word held at location 0.
- R7: Clear release is synchronised per clock. Enables seen at the first two active edges after release have no effect, and the third edge acts normally.
- R8: With CLR_POL = CLR_HIGH, WR_EDGE = EDGE_FALL and RD_EDGE = EDGE_FALL, and with inverted clocks and an inverted clear, the block behaves exactly as it does with the default active-low clear and rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclr | input | 1 | Asynchronous clear, polarity set by CLR_POL (active low by default) |
| wr_clk | input | 1 | Write clock, active edge set by WR_EDGE |
| wr_en | input | 1 | Write request, active high |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read clock, active edge set by RD_EDGE |
| rd_en | input | 1 | Read request, active high |
| rd_data | output | WIDTH | Registered word read out |

## Verification
A token lost or doubled in a ring, or a segment counter that steps at the wrong time, shows up at `rd_data` as a wrong or repeated word on the first read that reaches the bad location. A pointer that wraps early or late shows up within one pass of DEPTH words. A clear that does not zero both pointers, or a release that is not held for two edges, makes the first read after the clear return a stale or early word. A read register that loads while `rd_en` is low changes `rd_data` within one read period.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
  typedef enum logic {CLR_LOW = 1'b0, CLR_HIGH = 1'b1} clr_pol_e;
endpackage

// File: rtl/clr_sync.sv
module clr_sync (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/tok_ptr.sv
module tok_ptr #(
  parameter int DEPTH = 16,
  parameter int RING  = 4,
  localparam int NSEG = DEPTH / RING,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  logic [RING-1:0] ring_q, ring_d;
  logic [SW-1:0]   seg_q, seg_d;
  logic [AW-1:0]   idx;

  always_comb begin
    ring_d = ring_q;
    seg_d  = seg_q;
    if (adv) begin
      ring_d = {ring_q[RING-2:0], ring_q[RING-1]};
      if (ring_q[RING-1]) begin
        if (seg_q == SW'(NSEG - 1)) seg_d = '0;
        else                        seg_d = seg_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= RING'(1);
      seg_q  <= '0;
    end else begin
      ring_q <= ring_d;
      seg_q  <= seg_d;
    end
  end

  // token position to binary index
  always_comb begin
    idx = '0;
    for (int i = 0; i < RING; i++) begin
      if (ring_q[i]) idx = idx | AW'(i);
    end
  end

  assign addr = AW'(seg_q) * AW'(RING) + idx;

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == 1);
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> addr == (($past(addr) == AW'(DEPTH - 1)) ? '0 : $past(addr) + AW'(1)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(addr));
  a_r6_clear_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> addr == '0);
endmodule

// File: rtl/dp_store.sv
module dp_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_d;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata;
    if (re) rdata_d = mem[raddr];
  end

  always_ff @(posedge rclk) begin
    rdata <= rdata_d;
  end
endmodule

// File: rtl/flagless_dc_fifo.sv
module flagless_dc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int RING  = 4,
  parameter fifo_pkg::edge_e    WR_EDGE = fifo_pkg::EDGE_RISE,
  parameter fifo_pkg::edge_e    RD_EDGE = fifo_pkg::EDGE_RISE,
  parameter fifo_pkg::clr_pol_e CLR_POL = fifo_pkg::CLR_LOW,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             aclr,
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data
);
  logic wclk_e, rclk_e, clr_n;
  logic wr_rst_n, rd_rst_n;
  logic wr_go, rd_go;
  logic [AW-1:0] waddr, raddr;

  assign wclk_e = (WR_EDGE == fifo_pkg::EDGE_FALL) ? ~wr_clk : wr_clk;
  assign rclk_e = (RD_EDGE == fifo_pkg::EDGE_FALL) ? ~rd_clk : rd_clk;
  assign clr_n  = (CLR_POL == fifo_pkg::CLR_HIGH) ? ~aclr : aclr;

  clr_sync u_wsync (.clk(wclk_e), .clr_n(clr_n), .rst_n(wr_rst_n));
  clr_sync u_rsync (.clk(rclk_e), .clr_n(clr_n), .rst_n(rd_rst_n));

  assign wr_go = wr_en & wr_rst_n;
  assign rd_go = rd_en & rd_rst_n;

  tok_ptr #(.DEPTH(DEPTH), .RING(RING)) u_wptr (
    .clk(wclk_e), .rst_n(wr_rst_n), .adv(wr_go), .addr(waddr));
  tok_ptr #(.DEPTH(DEPTH), .RING(RING)) u_rptr (
    .clk(rclk_e), .rst_n(rd_rst_n), .adv(rd_go), .addr(raddr));

  dp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .wclk(wclk_e), .we(wr_go), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk_e), .re(rd_go), .raddr(raddr), .rdata(rd_data));

  a_r3_hold_idle: assert property (@(posedge rclk_e) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_data));
  a_r7_wr_frozen: assert property (@(posedge wclk_e)
    !wr_rst_n |=> waddr == '0);
endmodule

// File: tb/test_flagless_dc_fifo.sv
module test_flagless_dc_fifo;
  localparam int WIDTH = 8;
  localparam int DEPTH = 16;

  logic clr_n, wclk, rclk, wr_en, rd_en;
  logic [WIDTH-1:0] wr_data, rd_data, rd_data_alt;
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] last;
  int checks = 0, errors = 0;
  bit done = 0;

  flagless_dc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_flagless_dc_fifo (
    .aclr(clr_n), .wr_clk(wclk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rclk), .rd_en(rd_en), .rd_data(rd_data));

  flagless_dc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH),
    .WR_EDGE(fifo_pkg::EDGE_FALL), .RD_EDGE(fifo_pkg::EDGE_FALL),
    .CLR_POL(fifo_pkg::CLR_HIGH)) i_flagless_dc_fifo_alt (
    .aclr(~clr_n), .wr_clk(~wclk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(~rclk), .rd_en(rd_en), .rd_data(rd_data_alt));

  initial wclk = 0;
  always #10 wclk = ~wclk;   // 50 MHz
  initial rclk = 0;
  always #13 rclk = ~rclk;

  task automatic chk(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
    checks++;
    if (rd_data_alt !== act) begin
      errors++;
      $display("FAIL R8 actual %h expected %h", rd_data_alt, act);
    end
  endtask

  task automatic do_clear();
    @(posedge wclk); #3 clr_n = 0;
    #25 clr_n = 1;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
  endtask

  // driver: write n words, push each into the scoreboard after its edge
  task automatic wr_burst(int n, logic [WIDTH-1:0] base);
    @(posedge wclk); #1;
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = base + WIDTH'(i);
      @(posedge wclk); #1;
      q.push_back(base + WIDTH'(i));
    end
    wr_en = 0;
  endtask

  // monitor: read n words, pop and compare after each read edge
  task automatic rd_burst(int n, string tag);
    logic [WIDTH-1:0] e;
    @(posedge rclk); #1;
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      @(posedge rclk); #1;
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual empty expected data", tag);
      end else begin
        e = q.pop_front();
        chk(tag, rd_data, e);
        last = e;
      end
    end
    rd_en = 0;
  endtask

  task automatic rd_one(string tag, logic [WIDTH-1:0] exp);
    @(posedge rclk); #1 rd_en = 1;
    @(posedge rclk); #1 rd_en = 0;
    chk(tag, rd_data, exp);
    last = exp;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    #50 clr_n = 1;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);

    // R6: pointers start at 0, clear keeps storage
    wr_burst(3, 8'hA0);
    q.delete();
    do_clear();
    rd_one("R6", 8'hA0);
    rd_one("R6", 8'hA1);

    // R1: fill exactly DEPTH then drain
    do_clear();
    wr_burst(DEPTH, 8'h10);
    rd_burst(DEPTH, "R1");

    // R3: output holds while read enable low
    repeat (3) @(posedge rclk);
    #1 chk("R3", rd_data, last);

    // R4: continue across the wrap point
    wr_burst(6, 8'h40);
    rd_burst(6, "R4");

    // R2: concurrent streaming on unrelated clocks
    fork
      wr_burst(40, 8'h60);
      begin
        wait (q.size() >= 1);
        rd_burst(38, "R2");
      end
    join
    rd_burst(2, "R2");
    repeat (2) @(posedge rclk);
    #1 chk("R3", rd_data, last);

    // R5: DEPTH+1 writes overwrite location 0
    do_clear();
    wr_burst(DEPTH + 1, 8'hC0);
    q.delete();
    rd_one("R5", 8'hC0 + 8'(DEPTH));
    rd_one("R5", 8'hC1);

    // R7: first two write edges after release are ignored
    @(posedge wclk); #3 clr_n = 0; wr_en = 1; wr_data = 8'h5A;
    @(posedge wclk); #1 clr_n = 1;
    @(posedge wclk);
    @(posedge wclk); #1 wr_data = 8'h3C;
    @(posedge wclk); #1 wr_en = 0;
    repeat (4) @(posedge rclk);
    rd_one("R7", 8'h3C);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule